// File: doc/BRIEF.md
# Halt State Wake Controller

This block tracks whether the core is halted. When a halt instruction retires, the controller records the address of the instruction that follows it. It then enters a halted state and raises a request to gate the core clock. It stays there until a qualifying wake event arrives. Five event lines can end the halt: core reset, init, system management interrupt (SMI), non-maskable interrupt (NMI) and maskable interrupt. The maskable interrupt counts only while the interrupt flag is set.

On wake, the block publishes a wake-cause code and a resume pointer for handler entry. For the three interrupt causes, the pointer is the saved next-instruction address. For reset and init, it is the matching vector input. A handler entered through an SMI wake may finish with a return-to-halt request. The core then goes back to the halted state, and a later wake resumes at the address saved by the original halt.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After block reset (`rst_n` low), `halted_o`=0, `lp_req_o`=0, `wake_cause_o`=0 (none) and `resume_ip_o`=0.
- R2: A `halt_retire_i` pulse while not halted sets `halted_o` and `lp_req_o` from the next cycle and captures `next_ip_i`.
- R3: A `halt_retire_i` pulse while already halted is ignored: state is unchanged and the saved address is not overwritten.
- R4: While `intr_flag_i`=0, `evt_intr_i` does not wake the core. While it is 1, `evt_intr_i` does wake it.
- R5: Wake is taken in the first cycle a qualifying event is sampled while halted. `lp_req_o` falls combinationally in that cycle. `halted_o` clears, and `wake_cause_o`/`resume_ip_o` update, one cycle later.
- R6: When events coincide, the winner is chosen in the order reset, init, SMI, NMI, maskable interrupt. Cause codes are: 1 interrupt, 2 NMI, 3 SMI, 4 init, 5 reset.
- R7: On an interrupt, NMI or SMI wake, `resume_ip_o` is the address captured at halt entry.
- R8: On a reset or init wake, `resume_ip_o` is `reset_vec_i` or `init_vec_i` respectively, sampled in the wake cycle.
- R9: After an SMI wake, `smi_exit_i` with `smi_rehalt_i`=1 re-enters the halted state while keeping the saved address. An exit request with no SMI wake pending since the last exit is ignored.
- R10: Event lines have no effect while the core is not halted: `halted_o`, `wake_cause_o` and `resume_ip_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| halt_retire_i | input | 1 | Halt instruction retired strobe |
| next_ip_i | input | AW | Address of the instruction after the halt |
| intr_flag_i | input | 1 | Interrupt flag; enables maskable wake |
| evt_intr_i | input | 1 | Maskable interrupt line |
| evt_nmi_i | input | 1 | Non-maskable interrupt line |
| evt_smi_i | input | 1 | System management interrupt line |
| evt_init_i | input | 1 | Init line |
| evt_rst_i | input | 1 | Core reset line |
| reset_vec_i | input | AW | Resume target for a reset wake |
| init_vec_i | input | AW | Resume target for an init wake |
| smi_exit_i | input | 1 | SMI handler exit strobe |
| smi_rehalt_i | input | 1 | Qualifies `smi_exit_i`: return to halted state |
| halted_o | output | 1 | Core is halted |
| lp_req_o | output | 1 | Low-power / clock-gate request |
| wake_cause_o | output | 3 | Cause of the most recent wake |
| resume_ip_o | output | AW | Instruction pointer for handler entry |

## Verification
The bench holds a masked interrupt high for several cycles. A design that ignored the flag would wake early and report cause 1. It also drives pairs of events in the same cycle. A wrong priority order shows up as the wrong cause code, or as a resume pointer taken from a vector input instead of the saved address.

A second halt strobe carrying a different address is sent while halted. A design that recaptured it would resume at the wrong address. The SMI return-to-halt path is checked both inside and outside a pending SMI wake. A controller that re-halted on a stray exit request would hang the core with `halted_o` stuck high.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;
  localparam int NUM_EVT = 5;
  localparam int CW = 3;
  // request vector index: 0 intr, 1 nmi, 2 smi, 3 init, 4 reset; higher index wins
  localparam int IDX_INTR = 0;
  localparam int IDX_NMI  = 1;
  localparam int IDX_SMI  = 2;
  localparam int IDX_INIT = 3;
  localparam int IDX_RST  = 4;

  typedef enum logic [CW-1:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_INTR = 3'd1,
    CAUSE_NMI  = 3'd2,
    CAUSE_SMI  = 3'd3,
    CAUSE_INIT = 3'd4,
    CAUSE_RST  = 3'd5
  } wake_cause_e;

  function automatic logic [NUM_EVT-1:0] pick_highest(input logic [NUM_EVT-1:0] req);
    logic [NUM_EVT-1:0] g;
    logic found;
    g = '0;
    found = 1'b0;
    for (int i = NUM_EVT-1; i >= 0; i--) begin
      if (req[i] && !found) begin
        g[i] = 1'b1;
        found = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic wake_cause_e cause_of(input logic [NUM_EVT-1:0] g);
    if (g[IDX_RST])       return CAUSE_RST;
    else if (g[IDX_INIT]) return CAUSE_INIT;
    else if (g[IDX_SMI])  return CAUSE_SMI;
    else if (g[IDX_NMI])  return CAUSE_NMI;
    else if (g[IDX_INTR]) return CAUSE_INTR;
    else                  return CAUSE_NONE;
  endfunction
endpackage

// File: rtl/wake_arbiter.sv
module wake_arbiter
  import halt_wake_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] req_i,
  output logic [NUM_EVT-1:0] grant_o,
  output logic               any_o
);
  assign grant_o = pick_highest(req_i);
  assign any_o   = |req_i;

  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  a_r6_grant_when_req: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ($countones(grant_o) == 1));
endmodule

// File: rtl/halt_fsm.sv
module halt_fsm #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_retire_i,
  input  logic [AW-1:0] next_ip_i,
  input  logic          wake_fire_i,
  input  logic          grant_smi_i,
  input  logic          grant_hard_i,
  input  logic          smi_exit_i,
  input  logic          smi_rehalt_i,
  output logic          halted_o,
  output logic          lp_req_o,
  output logic [AW-1:0] saved_ip_o
);
  logic          halted_q, smm_q;
  logic [AW-1:0] saved_ip_q;
  logic          enter_halt, rehalt, smm_done;

  assign enter_halt = halt_retire_i && !halted_q;
  assign smm_done   = smi_exit_i && smm_q && !halted_q;
  assign rehalt     = smm_done && smi_rehalt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q   <= 1'b0;
      smm_q      <= 1'b0;
      saved_ip_q <= '0;
    end else begin
      if (enter_halt) begin
        halted_q   <= 1'b1;
        saved_ip_q <= next_ip_i;
      end else if (rehalt) begin
        halted_q <= 1'b1;
      end else if (wake_fire_i) begin
        halted_q <= 1'b0;
      end
      if (wake_fire_i && grant_smi_i)       smm_q <= 1'b1;
      else if (wake_fire_i && grant_hard_i) smm_q <= 1'b0;
      else if (smm_done)                    smm_q <= 1'b0;
    end
  end

  assign halted_o   = halted_q;
  assign lp_req_o   = halted_q && !wake_fire_i;
  assign saved_ip_o = saved_ip_q;

  a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_retire_i && !halted_q) |=> halted_q);
  a_r3_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_retire_i && halted_q) |=> $stable(saved_ip_q));
  a_r5_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_fire_i && !rehalt) |=> !halted_q);
  a_r5_lp_implies_halted: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req_o |-> halted_q);
  a_r9_rehalt: assert property (@(posedge clk) disable iff (!rst_n)
    rehalt |=> (halted_q && $stable(saved_ip_q)));
endmodule

// File: rtl/resume_sel.sv
module resume_sel
  import halt_wake_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wake_fire_i,
  input  logic [NUM_EVT-1:0] grant_i,
  input  logic [AW-1:0]      saved_ip_i,
  input  logic [AW-1:0]      reset_vec_i,
  input  logic [AW-1:0]      init_vec_i,
  output wake_cause_e        cause_o,
  output logic [AW-1:0]      ip_o
);
  wake_cause_e   cause_q, cause_d;
  logic [AW-1:0] ip_q, ip_d;

  function automatic logic [AW-1:0] target_of(input wake_cause_e c,
                                              input logic [AW-1:0] saved,
                                              input logic [AW-1:0] rv,
                                              input logic [AW-1:0] iv);
    case (c)
      CAUSE_RST:  return rv;
      CAUSE_INIT: return iv;
      default:    return saved;
    endcase
  endfunction

  assign cause_d = cause_of(grant_i);
  assign ip_d    = target_of(cause_d, saved_ip_i, reset_vec_i, init_vec_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_NONE;
      ip_q    <= '0;
    end else if (wake_fire_i) begin
      cause_q <= cause_d;
      ip_q    <= ip_d;
    end
  end

  assign cause_o = cause_q;
  assign ip_o    = ip_q;

  a_r8_reset_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_fire_i && grant_i[IDX_RST]) |=> (ip_q == $past(reset_vec_i)));
  a_r7_saved_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_fire_i && (grant_i[IDX_INTR] || grant_i[IDX_NMI] || grant_i[IDX_SMI]))
      |=> (ip_q == $past(saved_ip_i)));
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_fire_i |=> ($stable(ip_q) && $stable(cause_q)));
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_wake_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_retire_i,
  input  logic [AW-1:0] next_ip_i,
  input  logic          intr_flag_i,
  input  logic          evt_intr_i,
  input  logic          evt_nmi_i,
  input  logic          evt_smi_i,
  input  logic          evt_init_i,
  input  logic          evt_rst_i,
  input  logic [AW-1:0] reset_vec_i,
  input  logic [AW-1:0] init_vec_i,
  input  logic          smi_exit_i,
  input  logic          smi_rehalt_i,
  output logic          halted_o,
  output logic          lp_req_o,
  output logic [CW-1:0] wake_cause_o,
  output logic [AW-1:0] resume_ip_o
);
  logic [NUM_EVT-1:0] evt_req, evt_grant;
  logic               evt_any, wake_fire, halted_w;
  logic [AW-1:0]      saved_ip_w;
  wake_cause_e        cause_w;

  assign evt_req[IDX_INTR] = evt_intr_i && intr_flag_i;
  assign evt_req[IDX_NMI]  = evt_nmi_i;
  assign evt_req[IDX_SMI]  = evt_smi_i;
  assign evt_req[IDX_INIT] = evt_init_i;
  assign evt_req[IDX_RST]  = evt_rst_i;

  wake_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(evt_req), .grant_o(evt_grant), .any_o(evt_any)
  );

  assign wake_fire = halted_w && evt_any;

  halt_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .halt_retire_i(halt_retire_i), .next_ip_i(next_ip_i),
    .wake_fire_i(wake_fire),
    .grant_smi_i(evt_grant[IDX_SMI]),
    .grant_hard_i(evt_grant[IDX_RST] || evt_grant[IDX_INIT]),
    .smi_exit_i(smi_exit_i), .smi_rehalt_i(smi_rehalt_i),
    .halted_o(halted_w), .lp_req_o(lp_req_o), .saved_ip_o(saved_ip_w)
  );

  resume_sel #(.AW(AW)) u_res (
    .clk(clk), .rst_n(rst_n), .wake_fire_i(wake_fire), .grant_i(evt_grant),
    .saved_ip_i(saved_ip_w), .reset_vec_i(reset_vec_i), .init_vec_i(init_vec_i),
    .cause_o(cause_w), .ip_o(resume_ip_o)
  );

  assign halted_o     = halted_w;
  assign wake_cause_o = cause_w;

  a_r4_masked_intr_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_w && !intr_flag_i && !evt_nmi_i && !evt_smi_i && !evt_init_i && !evt_rst_i)
      |-> lp_req_o);
  a_r5_lp_drops_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_w && evt_nmi_i) |-> !lp_req_o);
endmodule

// File: tb/halt_wake_ctrl_tb.sv
module halt_wake_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic halt = 0, iflag = 0, ei = 0, en = 0, es = 0, eini = 0, er = 0, sx = 0, srh = 0;
  logic [AW-1:0] nip = '0;
  logic [AW-1:0] rvec = 32'hFFFF_FFF0, ivec = 32'h0000_8000;
  logic halted, lp;
  logic [2:0] cause;
  logic [AW-1:0] rip;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_wake_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt_retire_i(halt), .next_ip_i(nip),
    .intr_flag_i(iflag), .evt_intr_i(ei), .evt_nmi_i(en), .evt_smi_i(es),
    .evt_init_i(eini), .evt_rst_i(er), .reset_vec_i(rvec), .init_vec_i(ivec),
    .smi_exit_i(sx), .smi_rehalt_i(srh), .halted_o(halted), .lp_req_o(lp),
    .wake_cause_o(cause), .resume_ip_o(rip)
  );

  // behavioural reference model
  bit m_halt, m_smm;
  int m_cause;
  logic [AW-1:0] m_saved, m_ip;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_halt <= 0; m_smm <= 0; m_cause <= 0; m_saved <= '0; m_ip <= '0;
    end else if (!m_halt) begin
      if (halt) begin m_halt <= 1; m_saved <= nip; end
      else if (sx && m_smm) begin m_smm <= 0; if (srh) m_halt <= 1; end
    end else begin
      int c;
      c = er ? 5 : eini ? 4 : es ? 3 : en ? 2 : (ei && iflag) ? 1 : 0;
      if (c != 0) begin
        m_halt <= 0; m_cause <= c;
        m_ip <= (c == 5) ? rvec : (c == 4) ? ivec : m_saved;
        if (c == 3) m_smm <= 1; else if (c >= 4) m_smm <= 0;
      end
    end
  end

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  bit m_wake_now;
  always @(negedge clk) if (rst_n && !done) begin
    m_wake_now = m_halt && (er || eini || es || en || (ei && iflag));
    check("R2 halted", {31'b0, halted}, {31'b0, m_halt});
    check("R5 lp_req", {31'b0, lp}, {31'b0, m_halt && !m_wake_now});
    check("R6 cause", {29'b0, cause}, m_cause[AW-1:0]);
    check("R7 resume_ip", rip, m_ip);
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic do_halt(logic [AW-1:0] a);
    halt = 1; nip = a; step(); halt = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check("R1 halted", {31'b0, halted}, 0); check("R1 lp", {31'b0, lp}, 0);
    check("R1 cause", {29'b0, cause}, 0);   check("R1 ip", rip, 0);
    step(); rst_n = 1; step();
    // R10: events while running
    iflag = 1; ei = 1; en = 1; es = 1; step(); ei = 0; en = 0; es = 0; step();
    @(negedge clk);
    check("R10 halted", {31'b0, halted}, 0); check("R10 cause", {29'b0, cause}, 0);
    check("R10 ip", rip, 0);
    // R2 entry, then R3 second strobe
    step(); iflag = 0; do_halt(32'h100);
    @(negedge clk); check("R2 halted", {31'b0, halted}, 1); check("R2 lp", {31'b0, lp}, 1);
    step(); do_halt(32'h999);
    // R4 masked intr
    ei = 1; repeat (3) step();
    @(negedge clk); check("R4 masked", {31'b0, halted}, 1); check("R4 lp", {31'b0, lp}, 1);
    step(); iflag = 1;
    @(negedge clk); check("R5 lp drop", {31'b0, lp}, 0); check("R5 still halted", {31'b0, halted}, 1);
    step(); ei = 0;
    @(negedge clk); check("R5 cleared", {31'b0, halted}, 0);
    check("R4 cause intr", {29'b0, cause}, 1); check("R3 ip kept", rip, 32'h100);
    // R6: NMI beats interrupt
    step(); do_halt(32'h200); ei = 1; en = 1; step(); ei = 0; en = 0;
    @(negedge clk); check("R6 nmi", {29'b0, cause}, 2); check("R7 ip", rip, 32'h200);
    // R9: SMI wake, re-halt, then interrupt wake
    step(); do_halt(32'h300); es = 1; en = 1; step(); es = 0; en = 0;
    @(negedge clk); check("R6 smi", {29'b0, cause}, 3); check("R7 smi ip", rip, 32'h300);
    step(); sx = 1; srh = 1; step(); sx = 0; srh = 0;
    @(negedge clk); check("R9 rehalt", {31'b0, halted}, 1);
    step(); ei = 1; step(); ei = 0;
    @(negedge clk); check("R9 resume", rip, 32'h300); check("R9 halted", {31'b0, halted}, 0);
    step(); sx = 1; srh = 1; step(); sx = 0; srh = 0; step();
    @(negedge clk); check("R9 stray exit", {31'b0, halted}, 0);
    // R8: init over SMI, reset over init
    step(); do_halt(32'h400); eini = 1; es = 1; step(); eini = 0; es = 0;
    @(negedge clk); check("R8 init cause", {29'b0, cause}, 4); check("R8 init ip", rip, ivec);
    step(); do_halt(32'h500); er = 1; eini = 1; step(); er = 0; eini = 0;
    @(negedge clk); check("R8 rst cause", {29'b0, cause}, 5); check("R8 rst ip", rip, rvec);
    step(); step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule